// File: doc/BRIEF.md
# Pulse-Width Modulator Channel with General-Purpose I/O Fallback

This block drives one output pin either as a pulse-width modulated waveform or as an ordinary general-purpose I/O. A CPU-side register port holds a control word, a period value and a width value. In PWM mode a counter in a separate PCLK domain counts from zero up to the latched period. The pin is active while the count is below the latched width. At every period match the counter raises a single-cycle interrupt request.

Control bits cross from the CPU clock into PCLK through a two-flop synchronizer. Stopping the counter is deferred until the next period match. While stopped, the comparators follow the registers, the counter rests at zero and the pin sits at the polarity level. A forced-load request makes the comparators take the register values and restarts the counter once.

Top module: `pwmgp_top`

## Requirements
- R1: After reset every control bit, the period and the width read as zero, the pin is not driven (`pin_oe`=0) and `irq_o` is low.
- R2: With mode=0 and direction=1, the pin is driven (`pin_oe`=1) with the written data bit, and the polarity bit has no effect. Control word at address 0 has mode at bit 0, direction at bit 1, polarity at bit 2, data at bit 3, counter enable at bit 4, interrupt enable at bit 5 and forced load at bit 6.
- R3: With mode=0 and direction=0, `pin_oe` is 0 and control bit 3 reads back the synchronized `pin_in` level.
- R4: With mode=1, `pin_oe` is 1 whatever the direction bit holds, and control bit 3 reads back the level being driven on the pin.
- R5: With period P (address 1) and width W (address 2), W not above P, the running output repeats every P+1 PCLK cycles. In normal polarity it is high for the first W cycles after each period boundary, so W=0 gives a constantly low pin.
- R6: Polarity=1 inverts the PWM output. The pin is then high for P+1-W cycles of each period.
- R7: Clearing counter enable while the counter runs leaves the waveform running until the next period match. The counter then stops at zero and the pin holds the polarity level.
- R8: With interrupt enable set, `irq_o` pulses for exactly one PCLK cycle at every period match. This includes the match at which a deferred stop takes effect. With interrupt enable clear there are no pulses.
- R9: A new width or period written while running takes effect only at the next period boundary.
- R10: Writing 1 to the forced-load bit reloads both comparators from the registers and restarts the counter at zero once. The bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Synchronous active-low reset, CPU domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 period, 2 width |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr` (combinational) |
| pclk | input | 1 | Counter clock |
| prst_n | input | 1 | Synchronous active-low reset, PCLK domain |
| pin_in | input | 1 | Level observed at the pin |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |
| irq_o | output | 1 | Period-match interrupt request, one PCLK cycle wide |

## Verification
The counter assertions rely on four things about the inputs:
- Period and width register values stay steady for a few PCLK cycles before any reload that uses them.
- Forced-load writes are spaced further apart than the synchronizer latency.
- Each reset is held for at least one edge of its own clock.
- A new toggle therefore never overtakes the previous one.

The stimulus keeps to these conditions. It writes period and width well before enabling or force-loading. It issues a single forced load per test. It holds both resets for several cycles. It only changes values in mid-period when the test is meant to show that the change is deferred to the boundary.

// File: rtl/pwmgp_pkg.sv
// Package: register addresses, control-word bit positions and the
// control structure shared by the register file and the top level.
package pwmgp_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] A_WID  = 2'd2;

    localparam int B_MODE  = 0;
    localparam int B_DIR   = 1;
    localparam int B_POL   = 2;
    localparam int B_DATA  = 3;
    localparam int B_EN    = 4;
    localparam int B_IRQEN = 5;
    localparam int B_LOAD  = 6;

    typedef struct packed {
        logic irq_en;
        logic cnt_en;
        logic mode;
        logic pol;
        logic dir;
        logic dout;
    } ctrl_t;

endpackage

// File: rtl/pwmgp_sync.sv
// Multi-stage synchronizer, built as a parameterized flop chain.
// Assumes: each bit is either a level that changes rarely or part of a
// bus that holds steady across the synchronizer latency.
module pwmgp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // first capture flop takes the foreign-domain value
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // later flops let metastability settle
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= '0;
                    else        stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pwmgp_regs.sv
// CPU-side register file: control word, period and width.
// Forced load is turned into a toggle so that a single-cycle write
// survives the crossing. Reads are combinational.
// Assumes: pin_sync is already in the clk domain.
module pwmgp_regs
    import pwmgp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              pin_sync,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  per_q,
    output logic [CNT_W-1:0]  wid_q,
    output logic              ld_tog
);

    ctrl_t ctrl_q;
    logic  data_rb;

    // register writes; the forced-load bit flips the toggle and is not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            per_q  <= '0;
            wid_q  <= '0;
            ld_tog <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    ctrl_q.mode   <= wdata[B_MODE];
                    ctrl_q.dir    <= wdata[B_DIR];
                    ctrl_q.pol    <= wdata[B_POL];
                    ctrl_q.dout   <= wdata[B_DATA];
                    ctrl_q.cnt_en <= wdata[B_EN];
                    ctrl_q.irq_en <= wdata[B_IRQEN];
                    if (wdata[B_LOAD]) ld_tog <= ~ld_tog;
                end
                A_PER:   per_q <= wdata;
                A_WID:   wid_q <= wdata;
                default: ;
            endcase
        end
    end

    // data bit: the written value when driving as GPIO, else the sensed level
    always_comb begin
        data_rb = (!ctrl_q.mode && ctrl_q.dir) ? ctrl_q.dout : pin_sync;
    end

    // read mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_MODE]  = ctrl_q.mode;
                rdata[B_DIR]   = ctrl_q.dir;
                rdata[B_POL]   = ctrl_q.pol;
                rdata[B_DATA]  = data_rb;
                rdata[B_EN]    = ctrl_q.cnt_en;
                rdata[B_IRQEN] = ctrl_q.irq_en;
            end
            A_PER:   rdata = per_q;
            A_WID:   rdata = wid_q;
            default: rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/pwmgp_core.sv
// PCLK-domain counter and comparators.
// Stopped: the counter is held at zero and the latches track the registers.
// Running: the counter counts up to the period latch and wraps, the
// latches reload at each match, and the stop request is obeyed only at a
// match. A change of the synchronized load toggle forces a reload and a
// counter restart.
// Assumes: all inputs are already synchronized to pclk.
module pwmgp_core #(
    parameter int CNT_W = 16
) (
    input  logic             pclk,
    input  logic             prst_n,
    input  logic             en_s,
    input  logic             irq_en_s,
    input  logic             ld_s,
    input  logic [CNT_W-1:0] per_s,
    input  logic [CNT_W-1:0] wid_s,
    output logic             pwm_high,
    output logic             irq_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_l;
    logic [CNT_W-1:0] wid_l;
    logic             run_q;
    logic             ld_q;
    logic             irq_q;
    logic             hit;
    logic             ld_p;
    logic             reload;

    assign hit    = run_q && (cnt_q == per_l);
    assign ld_p   = ld_s ^ ld_q;
    assign reload = !run_q || ld_p || hit;

    // edge detector memory for the load toggle
    always_ff @(posedge pclk) begin
        if (!prst_n) ld_q <= 1'b0;
        else         ld_q <= ld_s;
    end

    // run state: start when enabled, stop only at a period match
    always_ff @(posedge pclk) begin
        if (!prst_n)     run_q <= 1'b0;
        else if (!run_q) run_q <= en_s;
        else if (hit)    run_q <= en_s;
    end

    // counter: held at zero when stopped, restarted on match or forced load
    always_ff @(posedge pclk) begin
        if (!prst_n)     cnt_q <= '0;
        else if (reload) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // comparator latches: copy the registers on stop, match or forced load
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            per_l <= '0;
            wid_l <= '0;
        end else if (reload) begin
            per_l <= per_s;
            wid_l <= wid_s;
        end
    end

    // interrupt request: one cycle per period match when enabled
    always_ff @(posedge pclk) begin
        if (!prst_n) irq_q <= 1'b0;
        else         irq_q <= hit && irq_en_s;
    end

    assign pwm_high = run_q && (cnt_q < wid_l);
    assign irq_o    = irq_q;

    // R5: a running counter never passes its period latch
    assert_cnt_in_range_R5: assert property (@(posedge pclk) disable iff (!prst_n)
        run_q |-> cnt_q <= per_l);

    // R7: a stopped counter rests at zero
    assert_idle_zero_R7: assert property (@(posedge pclk) disable iff (!prst_n)
        !run_q |-> cnt_q == '0);

    // R7: the counter can only stop at a period match
    assert_defer_stop_R7: assert property (@(posedge pclk) disable iff (!prst_n)
        (run_q && (cnt_q != per_l)) |=> run_q);

    // R7: a stopped counter never produces an active level
    assert_idle_low_R7: assert property (@(posedge pclk) disable iff (!prst_n)
        !run_q |-> !pwm_high);

    // R8: an interrupt request follows a cycle in which the counter ran
    assert_irq_after_run_R8: assert property (@(posedge pclk) disable iff (!prst_n)
        irq_o |-> $past(run_q));

    // R8: the request is a single-cycle pulse
    assert_irq_single_R8: assert property (@(posedge pclk) disable iff (!prst_n)
        irq_o |=> !irq_o || $past(hit));

endmodule

// File: rtl/pwmgp_top.sv
// Top: register file, both synchronizers, the counter core and the pin mux.
// Mode selects PWM or GPIO. In PWM mode the pin is always driven with the
// polarity-adjusted waveform; in GPIO mode direction and data apply.
// Assumes: period and width are steady whenever the core may reload.
module pwmgp_top
    import pwmgp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              pclk,
    input  logic              prst_n,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq_o
);

    localparam int XW = 3 + 2 * CNT_W;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] wid_q;
    logic             ld_tog;
    logic             pin_sync;
    logic             pin_level;
    logic             pwm_high;
    logic [XW-1:0]    x_cpu;
    logic [XW-1:0]    x_pclk;

    pwmgp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .pin_sync (pin_sync),
        .ctrl     (ctrl),
        .per_q    (per_q),
        .wid_q    (wid_q),
        .ld_tog   (ld_tog)
    );

    assign x_cpu = {ctrl.irq_en, ctrl.cnt_en, ld_tog, per_q, wid_q};

    pwmgp_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_to_pclk (
        .clk   (pclk),
        .rst_n (prst_n),
        .d     (x_cpu),
        .q     (x_pclk)
    );

    pwmgp_core #(.CNT_W(CNT_W)) u_core (
        .pclk     (pclk),
        .prst_n   (prst_n),
        .en_s     (x_pclk[XW-2]),
        .irq_en_s (x_pclk[XW-1]),
        .ld_s     (x_pclk[XW-3]),
        .per_s    (x_pclk[2*CNT_W-1:CNT_W]),
        .wid_s    (x_pclk[CNT_W-1:0]),
        .pwm_high (pwm_high),
        .irq_o    (irq_o)
    );

    // pin mux: PWM waveform with polarity, or the GPIO data bit
    always_comb begin
        pin_oe  = ctrl.mode | ctrl.dir;
        pin_out = ctrl.mode ? (ctrl.pol ^ pwm_high) : ctrl.dout;
    end

    // level at the pin, as seen for readback
    always_comb begin
        pin_level = pin_oe ? pin_out : pin_in;
    end

    pwmgp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_to_cpu (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_level),
        .q     (pin_sync)
    );

    // R4: in PWM mode, a stopped channel drives the pin at the polarity level
    assert_pwm_idle_pol_R4: assert property (@(posedge pclk) disable iff (!prst_n)
        (ctrl.mode && !pwm_high) |-> (pin_oe && pin_out == ctrl.pol));

endmodule

// File: tb/tb_pwmgp_top.sv
module tb_pwmgp_top;
    import pwmgp_pkg::*;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             pclk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       addr = 2'd0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic             pin_in = 1'b0;
    logic             pin_out;
    logic             pin_oe;
    logic             irq_o;

    int checks = 0;
    int errors = 0;

    pwmgp_top #(.CNT_W(CNT_W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pclk    (pclk),
        .prst_n  (prst_n),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq_o   (irq_o)
    );

    always #10 clk = ~clk;
    initial begin
        #5;
        forever #20 pclk = ~pclk;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
        @(negedge clk);
        addr = a;
        #2;
        d = rdata;
    endtask

    task automatic wr_ctrl(input bit mode, input bit dir, input bit pol, input bit dout,
                           input bit en, input bit irqen, input bit load);
        logic [CNT_W-1:0] w;
        w = '0;
        w[B_MODE] = mode;
        w[B_DIR] = dir;
        w[B_POL] = pol;
        w[B_DATA] = dout;
        w[B_EN] = en;
        w[B_IRQEN] = irqen;
        w[B_LOAD] = load;
        wr(A_CTRL, w);
    endtask

    task automatic pwait(input int n);
        repeat (n) @(negedge pclk);
    endtask

    task automatic wait_edge(input logic rise, output bit ok);
        logic prev;
        ok = 1'b0;
        @(negedge pclk);
        prev = pin_out;
        for (int i = 0; i < 2000; i++) begin
            @(negedge pclk);
            if (prev !== rise && pin_out === rise) begin
                ok = 1'b1;
                break;
            end
            prev = pin_out;
        end
    endtask

    task automatic measure(output int hi, output int per);
        bit   ok;
        logic prev;
        hi = 0;
        per = 0;
        wait_edge(1'b1, ok);
        if (!ok) begin
            hi = -1;
            per = -1;
            return;
        end
        for (int i = 0; i < 2000; i++) begin
            if (pin_out) hi++;
            per++;
            prev = pin_out;
            @(negedge pclk);
            if (!prev && pin_out) break;
        end
    endtask

    task automatic count_irq(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge pclk);
            if (irq_o) c++;
        end
    endtask

    task automatic t_reset;
        logic [CNT_W-1:0] d;
        rd(A_CTRL, d);
        check(d == '0, "R1 ctrl", int'(d), 0);
        rd(A_PER, d);
        check(d == '0, "R1 period", int'(d), 0);
        rd(A_WID, d);
        check(d == '0, "R1 width", int'(d), 0);
        check(pin_oe == 1'b0, "R1 pin_oe", int'(pin_oe), 0);
        check(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    endtask

    task automatic t_gpio_out;
        logic [CNT_W-1:0] d;
        wr_ctrl(0, 1, 1, 1, 0, 0, 0);
        #1;
        check(pin_oe == 1'b1, "R2 oe", int'(pin_oe), 1);
        check(pin_out == 1'b1, "R2 data=1 pol=1", int'(pin_out), 1);
        wr_ctrl(0, 1, 1, 0, 0, 0, 0);
        #1;
        check(pin_out == 1'b0, "R2 data=0 pol=1", int'(pin_out), 0);
        rd(A_CTRL, d);
        check(d[B_DATA] == 1'b0, "R2 readback", int'(d[B_DATA]), 0);
    endtask

    task automatic t_gpio_in;
        logic [CNT_W-1:0] d;
        wr_ctrl(0, 0, 0, 0, 0, 0, 0);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(pin_oe == 1'b0, "R3 oe", int'(pin_oe), 0);
        rd(A_CTRL, d);
        check(d[B_DATA] == 1'b1, "R3 read pin=1", int'(d[B_DATA]), 1);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(A_CTRL, d);
        check(d[B_DATA] == 1'b0, "R3 read pin=0", int'(d[B_DATA]), 0);
    endtask

    task automatic t_pwm_basic;
        int hi, per, c;
        wr(A_PER, 16'd9);
        wr(A_WID, 16'd3);
        wr_ctrl(1, 0, 0, 0, 1, 1, 0);
        #1;
        check(pin_oe == 1'b1, "R4 oe with dir=0", int'(pin_oe), 1);
        pwait(20);
        measure(hi, per);
        check(per == 10, "R5 period", per, 10);
        check(hi == 3, "R5 high time", hi, 3);
        pwait(3);
        count_irq(100, c);
        check(c == 10, "R8 irq per match", c, 10);
        wr_ctrl(1, 0, 1, 0, 1, 1, 0);
        pwait(5);
        measure(hi, per);
        check(hi == 7, "R6 inverted high time", hi, 7);
        check(per == 10, "R6 inverted period", per, 10);
    endtask

    task automatic t_zero_width;
        int hi;
        wr_ctrl(1, 0, 0, 0, 1, 0, 0);
        wr(A_WID, 16'd0);
        pwait(30);
        hi = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge pclk);
            if (pin_out) hi++;
        end
        check(hi == 0, "R5 width zero", hi, 0);
    endtask

    task automatic t_reload_boundary;
        bit ok;
        int hi, per;
        wr(A_PER, 16'd79);
        wr(A_WID, 16'd10);
        pwait(100);
        wait_edge(1'b0, ok);
        check(ok, "R9 fall seen", int'(ok), 1);
        wr(A_WID, 16'd40);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge pclk);
            if (pin_out) hi++;
        end
        check(hi == 0, "R9 no mid-period change", hi, 0);
        measure(hi, per);
        check(hi == 40, "R9 new width at boundary", hi, 40);
        check(per == 80, "R9 period", per, 80);
    endtask

    task automatic t_force_load;
        bit ok;
        int n, hi, per;
        logic [CNT_W-1:0] d;
        wr(A_WID, 16'd10);
        pwait(200);
        wait_edge(1'b0, ok);
        wr(A_WID, 16'd5);
        wr(A_PER, 16'd19);
        wr_ctrl(1, 0, 0, 0, 1, 0, 1);
        n = 0;
        while (!pin_out && n < 100) begin
            @(negedge pclk);
            n++;
        end
        check(n < 20, "R10 restart delay", n, 20);
        measure(hi, per);
        check(hi == 5, "R10 loaded width", hi, 5);
        check(per == 20, "R10 loaded period", per, 20);
        rd(A_CTRL, d);
        check(d[B_LOAD] == 1'b0, "R10 load bit reads 0", int'(d[B_LOAD]), 0);
    endtask

    task automatic t_deferred_stop;
        bit ok;
        int rises, c;
        logic prev;
        logic [CNT_W-1:0] d;
        wr(A_PER, 16'd79);
        wr(A_WID, 16'd40);
        wr_ctrl(1, 0, 0, 0, 1, 1, 0);
        pwait(200);
        wait_edge(1'b1, ok);
        wr_ctrl(1, 0, 0, 0, 0, 1, 0);
        pwait(5);
        check(pin_out == 1'b1, "R7 still running", int'(pin_out), 1);
        rises = 0;
        c = 0;
        prev = pin_out;
        for (int i = 0; i < 300; i++) begin
            @(negedge pclk);
            if (!prev && pin_out) rises++;
            if (irq_o) c++;
            prev = pin_out;
        end
        check(rises == 0, "R7 stopped after match", rises, 0);
        check(c == 1, "R8 irq at final match", c, 1);
        check(pin_out == 1'b0, "R7 idle at pol=0", int'(pin_out), 0);
        wr_ctrl(1, 0, 1, 0, 0, 0, 0);
        pwait(2);
        check(pin_out == 1'b1, "R7 idle at pol=1", int'(pin_out), 1);
        repeat (4) @(negedge clk);
        rd(A_CTRL, d);
        check(d[B_DATA] == 1'b1, "R4 data reads pin level", int'(d[B_DATA]), 1);
    endtask

    task automatic t_irq_off;
        int c;
        wr(A_PER, 16'd9);
        wr(A_WID, 16'd3);
        wr_ctrl(1, 0, 0, 0, 1, 0, 0);
        pwait(20);
        count_irq(100, c);
        check(c == 0, "R8 no irq when disabled", c, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge pclk);
        rst_n = 1'b1;
        prst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_gpio_out();
        t_gpio_in();
        t_pwm_basic();
        t_zero_width();
        t_reload_boundary();
        t_force_load();
        t_deferred_stop();
        t_irq_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule